// File: doc/BRIEF.md
# Programmable IR Pulse-Timing Decoder

This block watches one infrared receiver line and turns a burst of marks and spaces into a data word of up to 64 bits. Each mark is paired with the space that follows it. The pair is accepted only when two conditions hold. The mark width must fall inside a programmed width window. The full mark-plus-space period must fall inside a separate programmed period window. One optional leader window opens a frame, and four data windows each yield a bit. A long quiet space ends the frame.

At frame end the decoder compares the number of received bits with programmed even-valued bounds. A frame that passes is latched into a low and a high 32-bit word, together with its length and a valid flag. The flag holds the result until the host clears it. The host sets the windows, the gap threshold, the bounds and a few control bits directly through input ports.

Top module: `irpt_decoder`

## Requirements
- R1: `ir_in` passes through a two-flop synchronizer. The mark level is 1 when `ctl_rx_invert`=0 and 0 when `ctl_rx_invert`=1.
- R2: Each data window `k` sits at `win_data[32k +: 32]` as {period max [31:24], period min [23:16], width max [15:8], width min [7:0]}. A pair matches when min ≤ mark clocks ≤ max and min ≤ (mark+space clocks)>>1 ≤ max, with all bounds inclusive. Windows 0 and 2 give bit 0, windows 1 and 3 give bit 1, and when several windows match the lowest index wins.
- R3: `win_leader` has the same layout, but both the width and the period are compared after a right shift by 4. With `ctl_need_leader`=1, the first pair of a frame must match the leader window; otherwise the frame is discarded.
- R4: With `ctl_need_leader`=0, the first pair of a frame is decoded as a data bit.
- R5: A space whose clock count, shifted right by 3, exceeds `gap_min` ends the frame. The mark before that space is not classified.
- R6: A frame is accepted only if its bit count n satisfies 2·floor(`len_lo`/2) ≤ n ≤ min(2·floor(`len_hi`/2), 48).
- R7: With `ctl_msb_first`=0 the first received bit lands in bit 0 of the 64-bit result. With `ctl_msb_first`=1 it lands in bit n−1.
- R8: `ctl_bit_invert`=1 complements every decoded bit before it is stored.
- R9: An accepted frame drives `data_lo` (result bits 31:0), `data_hi` (bits 63:32) and `rx_len`, and sets `rx_valid`. These hold until a `clr_valid` pulse clears `rx_valid`. A frame that completes while `rx_valid` is set is dropped. After reset all outputs are 0.
- R10: A pair that matches no window aborts the frame without setting `rx_valid`. The next frame after the gap is decoded normally.
- R11: While `ctl_enable`=0, no frame is accepted and any frame in progress is abandoned.
- R12: The mark and space counters saturate at 2^CNT_W−1 instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ir_in | input | 1 | Raw receiver line |
| ctl_enable | input | 1 | Decode enable |
| ctl_rx_invert | input | 1 | Line polarity select |
| ctl_msb_first | input | 1 | First bit lands at the MSB end |
| ctl_bit_invert | input | 1 | Complement decoded bits |
| ctl_need_leader | input | 1 | Frame must open with a leader |
| win_leader | input | 32 | Leader window (units of 16 clocks) |
| win_data | input | 128 | Four data windows |
| gap_min | input | 8 | Free-time threshold (units of 8 clocks) |
| len_lo | input | 5 | Minimum frame length |
| len_hi | input | 6 | Maximum frame length |
| clr_valid | input | 1 | Clears the valid flag |
| data_lo | output | 32 | Result bits 31:0 |
| data_hi | output | 32 | Result bits 63:32 |
| rx_len | output | 7 | Received bit count |
| rx_valid | output | 1 | Result valid |

## Verification
The bench sweeps frame lengths that straddle the 32-bit word boundary, under every combination of bit order and bit inversion, while alternating line polarity and symbol shapes. Wrong word packing, reversed order or a missed inversion therefore shows up as wrong data. Mark and period values just inside and just outside each window catch off-by-one or exclusive comparisons, and an overlap case catches a wrong priority order. Length bounds with odd programmed values and the cap at 48 expose a design that fails to round down to an even value. A lowered gap threshold shows whether a long space really ends the frame. A mark longer than the counter range would alias into a valid width in a wrapping design, and the bench checks that it does not.

// File: rtl/irpt_pkg.sv
package irpt_pkg;
    localparam int FIELD_W = 8;
    localparam int WIN_W   = 4 * FIELD_W;
    localparam int N_SYM   = 4;
    localparam int DATA_W  = 64;
    localparam int LEN_W   = $clog2(DATA_W + 1);
    localparam int CMP_W   = 32;
    localparam int LDR_SH  = 4;
    localparam int PD_SH   = 1;
    localparam int GAP_SH  = 3;

    typedef struct packed {
        logic [FIELD_W-1:0] pd_max;
        logic [FIELD_W-1:0] pd_min;
        logic [FIELD_W-1:0] w_max;
        logic [FIELD_W-1:0] w_min;
    } sym_win_t;

    typedef enum logic [1:0] {
        FR_IDLE = 2'd0,
        FR_BITS = 2'd1,
        FR_DROP = 2'd2
    } frame_st_e;

    function automatic logic win_hit(sym_win_t win, logic [CMP_W-1:0] w_sc,
                                     logic [CMP_W-1:0] p_sc);
        return (w_sc >= CMP_W'(win.w_min)) && (w_sc <= CMP_W'(win.w_max)) &&
               (p_sc >= CMP_W'(win.pd_min)) && (p_sc <= CMP_W'(win.pd_max));
    endfunction
endpackage

// File: rtl/irpt_sync.sv
module irpt_sync (
    input  logic clk,
    input  logic rst,
    input  logic din,
    input  logic invert,
    output logic mark
);
    logic s1, s2;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1 <= 1'b0;
            s2 <= 1'b0;
        end else begin
            s1 <= din;
            s2 <= s1;
        end
    end

    assign mark = s2 ^ invert;
endmodule

// File: rtl/irpt_meas.sv
module irpt_meas
    import irpt_pkg::*;
#(
    parameter int CNT_W = 14
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               mark,
    input  logic [FIELD_W-1:0] gap_min,
    output logic               pair_v,
    output logic [CNT_W-1:0]   pair_w,
    output logic [CNT_W-1:0]   pair_s,
    output logic               gap_v
);
    localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

    logic             prev, mdone, gseen;
    logic [CNT_W-1:0] mcnt, scnt, mlen;
    logic             gap_hit;

    assign gap_hit = (CMP_W'(scnt) >> GAP_SH) > CMP_W'(gap_min);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev   <= 1'b0;
            mdone  <= 1'b0;
            gseen  <= 1'b1;
            mcnt   <= '0;
            scnt   <= '0;
            mlen   <= '0;
            pair_v <= 1'b0;
            pair_w <= '0;
            pair_s <= '0;
            gap_v  <= 1'b0;
        end else begin
            pair_v <= 1'b0;
            gap_v  <= 1'b0;
            prev   <= mark;
            if (mark) begin
                if (!prev) begin
                    mcnt  <= CNT_W'(1);
                    mdone <= 1'b0;
                    if (mdone) begin
                        pair_v <= 1'b1;
                        pair_w <= mlen;
                        pair_s <= scnt;
                    end
                end else if (mcnt != CMAX) begin
                    mcnt <= mcnt + CNT_W'(1);
                end
            end else begin
                if (prev) begin
                    mlen  <= mcnt;
                    mdone <= 1'b1;
                    scnt  <= CNT_W'(1);
                    gseen <= 1'b0;
                end else begin
                    if (scnt != CMAX) scnt <= scnt + CNT_W'(1);
                    if (!gseen && gap_hit) begin
                        gap_v <= 1'b1;
                        gseen <= 1'b1;
                        mdone <= 1'b0;
                    end
                end
            end
        end
    end

    // R12: a saturated mark count stays saturated while the mark lasts
    a_r12_mark_sat: assert property (@(posedge clk) disable iff (rst)
        (mark && prev && mcnt == CMAX) |=> (mcnt == CMAX));
    // R5: a frame-end pulse only follows a cycle spent in space
    a_r5_gap_in_space: assert property (@(posedge clk) disable iff (rst)
        gap_v |-> !$past(mark));
endmodule

// File: rtl/irpt_classify.sv
module irpt_classify
    import irpt_pkg::*;
#(
    parameter int CNT_W = 14
) (
    input  logic [CNT_W-1:0]       pair_w,
    input  logic [CNT_W-1:0]       pair_s,
    input  logic [WIN_W-1:0]       win_leader,
    input  logic [N_SYM*WIN_W-1:0] win_data,
    output logic                   ldr_hit,
    output logic                   dat_hit,
    output logic                   dat_bit
);
    logic [CMP_W-1:0] w_x, p_x;
    logic [N_SYM-1:0] hit;

    assign w_x = CMP_W'(pair_w);
    assign p_x = CMP_W'(pair_w) + CMP_W'(pair_s);

    assign ldr_hit = win_hit(sym_win_t'(win_leader), w_x >> LDR_SH, p_x >> LDR_SH);

    for (genvar k = 0; k < N_SYM; k++) begin : g_win
        assign hit[k] = win_hit(sym_win_t'(win_data[k*WIN_W +: WIN_W]), w_x, p_x >> PD_SH);
    end

    always_comb begin
        dat_hit = 1'b0;
        dat_bit = 1'b0;
        for (int k = N_SYM - 1; k >= 0; k--) begin
            if (hit[k]) begin
                dat_hit = 1'b1;
                dat_bit = 1'((k % 2));
            end
        end
    end
endmodule

// File: rtl/irpt_decoder.sv
module irpt_decoder
    import irpt_pkg::*;
#(
    parameter int CNT_W   = 14,
    parameter int LEN_CAP = 48
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   ir_in,
    input  logic                   ctl_enable,
    input  logic                   ctl_rx_invert,
    input  logic                   ctl_msb_first,
    input  logic                   ctl_bit_invert,
    input  logic                   ctl_need_leader,
    input  logic [WIN_W-1:0]       win_leader,
    input  logic [N_SYM*WIN_W-1:0] win_data,
    input  logic [FIELD_W-1:0]     gap_min,
    input  logic [4:0]             len_lo,
    input  logic [5:0]             len_hi,
    input  logic                   clr_valid,
    output logic [31:0]            data_lo,
    output logic [31:0]            data_hi,
    output logic [LEN_W-1:0]       rx_len,
    output logic                   rx_valid
);
    logic               mark, meas_rst;
    logic               pair_v, gap_v;
    logic [CNT_W-1:0]   pair_w, pair_s;
    logic               ldr_hit, dat_hit, dat_bit, nb;
    frame_st_e          st;
    logic [LEN_W-1:0]   cnt, lmin, lmax_raw, lmax;
    logic [DATA_W-1:0]  sr;
    logic               len_ok;

    assign meas_rst = rst || !ctl_enable;

    irpt_sync u_sync (
        .clk(clk), .rst(rst), .din(ir_in), .invert(ctl_rx_invert), .mark(mark)
    );

    irpt_meas #(.CNT_W(CNT_W)) u_meas (
        .clk(clk), .rst(meas_rst), .mark(mark), .gap_min(gap_min),
        .pair_v(pair_v), .pair_w(pair_w), .pair_s(pair_s), .gap_v(gap_v)
    );

    irpt_classify #(.CNT_W(CNT_W)) u_cls (
        .pair_w(pair_w), .pair_s(pair_s), .win_leader(win_leader),
        .win_data(win_data), .ldr_hit(ldr_hit), .dat_hit(dat_hit), .dat_bit(dat_bit)
    );

    assign nb       = dat_bit ^ ctl_bit_invert;
    assign lmin     = LEN_W'({len_lo[4:1], 1'b0});
    assign lmax_raw = LEN_W'({len_hi[5:1], 1'b0});
    assign lmax     = (lmax_raw > LEN_W'(LEN_CAP)) ? LEN_W'(LEN_CAP) : lmax_raw;
    assign len_ok   = (cnt >= lmin) && (cnt <= lmax);

    always_ff @(posedge clk) begin
        if (rst || !ctl_enable) begin
            st  <= FR_IDLE;
            cnt <= '0;
            sr  <= '0;
        end else if (gap_v) begin
            st <= FR_IDLE;
        end else if (pair_v) begin
            case (st)
                FR_IDLE: begin
                    if (ctl_need_leader) begin
                        st  <= ldr_hit ? FR_BITS : FR_DROP;
                        cnt <= '0;
                        sr  <= '0;
                    end else if (dat_hit) begin
                        st  <= FR_BITS;
                        cnt <= LEN_W'(1);
                        sr  <= DATA_W'(nb);
                    end else begin
                        st <= FR_DROP;
                    end
                end
                FR_BITS: begin
                    if (!dat_hit || cnt == LEN_W'(DATA_W)) begin
                        st <= FR_DROP;
                    end else begin
                        cnt <= cnt + LEN_W'(1);
                        if (ctl_msb_first) sr <= {sr[DATA_W-2:0], nb};
                        else               sr <= sr | (DATA_W'(nb) << cnt[LEN_W-2:0]);
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            data_lo  <= '0;
            data_hi  <= '0;
            rx_len   <= '0;
            rx_valid <= 1'b0;
        end else begin
            if (clr_valid) rx_valid <= 1'b0;
            if (ctl_enable && gap_v && st == FR_BITS && len_ok && !rx_valid) begin
                data_lo  <= sr[31:0];
                data_hi  <= sr[DATA_W-1:32];
                rx_len   <= cnt;
                rx_valid <= 1'b1;
            end
        end
    end

    // R9: result holds while valid and not cleared
    a_r9_hold: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && !clr_valid) |=> (rx_valid && $stable(data_lo) &&
                                      $stable(data_hi) && $stable(rx_len)));
    // R9: a clear pulse drops the flag
    a_r9_clear: assert property (@(posedge clk) disable iff (rst)
        clr_valid |=> !rx_valid);
    // R6: no accepted length above the cap
    a_r6_len_cap: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_valid) |-> (rx_len <= LEN_W'(LEN_CAP)));
    // R10: an aborted frame never raises valid at its end
    a_r10_abort_quiet: assert property (@(posedge clk) disable iff (rst)
        (st == FR_DROP && gap_v) |=> !$rose(rx_valid));
    // R11: decoding held idle while disabled
    a_r11_off_idle: assert property (@(posedge clk) disable iff (rst)
        !ctl_enable |=> (st == FR_IDLE && !$rose(rx_valid)));
endmodule

// File: tb/irpt_decoder_tb.sv
module irpt_decoder_tb_top;
    localparam int CLK_T = 10;
    localparam int WDOG  = 190000;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         ir_in = 1'b0;
    logic         ctl_enable = 1'b1, ctl_rx_invert = 1'b0, ctl_msb_first = 1'b0;
    logic         ctl_bit_invert = 1'b0, ctl_need_leader = 1'b1;
    logic [31:0]  win_leader;
    logic [127:0] win_data;
    logic [7:0]   gap_min = 8'd10;
    logic [4:0]   len_lo = 5'd0;
    logic [5:0]   len_hi = 6'd63;
    logic         clr_valid = 1'b0;
    logic [31:0]  data_lo, data_hi;
    logic [6:0]   rx_len;
    logic         rx_valid;

    int n_chk = 0, n_fail = 0, cyc = 0;

    function automatic logic [31:0] mkwin(int pmax, int pmin, int wmax, int wmin);
        return {8'(pmax), 8'(pmin), 8'(wmax), 8'(wmin)};
    endfunction

    localparam logic [31:0] W0 = {8'd7, 8'd5, 8'd6, 8'd4};
    localparam logic [31:0] W1 = {8'd12, 8'd9, 8'd6, 8'd4};
    localparam logic [31:0] W2 = {8'd12, 8'd9, 8'd12, 8'd10};
    localparam logic [31:0] W3 = {8'd16, 8'd14, 8'd12, 8'd10};

    irpt_decoder dut_i (
        .clk(clk), .rst(rst), .ir_in(ir_in), .ctl_enable(ctl_enable),
        .ctl_rx_invert(ctl_rx_invert), .ctl_msb_first(ctl_msb_first),
        .ctl_bit_invert(ctl_bit_invert), .ctl_need_leader(ctl_need_leader),
        .win_leader(win_leader), .win_data(win_data), .gap_min(gap_min),
        .len_lo(len_lo), .len_hi(len_hi), .clr_valid(clr_valid),
        .data_lo(data_lo), .data_hi(data_hi), .rx_len(rx_len), .rx_valid(rx_valid)
    );

    always #(CLK_T/2) clk = ~clk;

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == WDOG) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            summary();
            $finish;
        end
    end

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive(logic m, int n);
        ir_in = m ^ ctl_rx_invert;
        repeat (n) @(negedge clk);
    endtask

    task automatic pair(int m, int s);
        drive(1'b1, m);
        drive(1'b0, s);
    endtask

    task automatic tail();
        pair(5, 120);
    endtask

    task automatic bits_out(logic [63:0] b, int n, logic lng);
        for (int i = 0; i < n; i++) begin
            if (lng) pair(11, b[i] ? 19 : 9);
            else     pair(5, b[i] ? 15 : 5);
        end
    endtask

    task automatic frame(logic [63:0] b, int n, logic lng);
        pair(60, 40);
        bits_out(b, n, lng);
        tail();
    endtask

    function automatic logic [63:0] expv(logic [63:0] b, int n, logic msb, logic inv);
        logic [63:0] e;
        e = '0;
        for (int i = 0; i < n; i++) begin
            if (msb) e[n-1-i] = b[i] ^ inv;
            else     e[i] = b[i] ^ inv;
        end
        return e;
    endfunction

    task automatic expect_frame(string req, logic [63:0] e, int n);
        chk(req, 64'(rx_valid), 64'd1);
        chk(req, 64'(data_lo), 64'(e[31:0]));
        chk(req, 64'(data_hi), 64'(e[63:32]));
        chk(req, 64'(rx_len), 64'(n));
    endtask

    task automatic clear();
        clr_valid = 1'b1;
        @(negedge clk);
        clr_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic set_pol(logic v);
        ctl_rx_invert = v;
        ir_in = v;
        repeat (150) @(negedge clk);
    endtask

    initial begin
        int lens[6];
        logic [63:0] base, pat;
        lens = '{2, 8, 31, 32, 33, 48};
        base = 64'h9E37_79B9_7F4A_7C15;
        win_leader = mkwin(6, 5, 4, 3);
        win_data = {W3, W2, W1, W0};
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (30) @(negedge clk);

        // R9 reset state
        chk("R9 reset valid", 64'(rx_valid), 64'd0);
        chk("R9 reset data", {data_hi, data_lo}, 64'd0);
        chk("R9 reset len", 64'(rx_len), 64'd0);

        // R1 R2 R3 R7 R8 sweep over length, order, inversion, polarity, symbol shape
        for (int li = 0; li < 6; li++) begin
            for (int cfg = 0; cfg < 4; cfg++) begin
                int r;
                r = (li * 4 + cfg) * 5 + 1;
                pat = (base << r) | (base >> (64 - r));
                set_pol(1'((li + cfg) % 2));
                ctl_msb_first = cfg[0];
                ctl_bit_invert = cfg[1];
                frame(pat, lens[li], 1'(li % 2));
                expect_frame("R1 R2 R7 R8 sweep", expv(pat, lens[li], cfg[0], cfg[1]), lens[li]);
                clear();
            end
        end
        set_pol(1'b0);
        ctl_msb_first = 1'b0;
        ctl_bit_invert = 1'b0;

        // R2 window boundaries: special pair then three zero bits
        pair(60, 40); pair(3, 5); bits_out(64'd0, 3, 1'b0); tail();
        chk("R2 width below min", 64'(rx_valid), 64'd0);
        pair(60, 40); pair(4, 6); bits_out(64'd0, 3, 1'b0); tail();
        expect_frame("R2 low edge", 64'd0, 4); clear();
        pair(60, 40); pair(6, 9); bits_out(64'd0, 3, 1'b0); tail();
        expect_frame("R2 high edge", 64'd0, 4); clear();
        pair(60, 40); pair(7, 5); bits_out(64'd0, 3, 1'b0); tail();
        chk("R2 width above max", 64'(rx_valid), 64'd0);
        pair(60, 40); pair(6, 10); bits_out(64'd0, 3, 1'b0); tail();
        chk("R2 period gap", 64'(rx_valid), 64'd0);
        pair(60, 40); pair(5, 13); bits_out(64'd0, 3, 1'b0); tail();
        expect_frame("R2 bit one low edge", 64'd1, 4); clear();
        // R2 priority: window 1 overlapping window 0
        win_data = {W3, W2, W0, W0};
        frame(64'd0, 4, 1'b0);
        expect_frame("R2 priority", 64'd0, 4); clear();
        win_data = {W3, W2, W1, W0};

        // R3 leader scaling and necessity
        pair(47, 40); bits_out(64'h5, 4, 1'b0); tail();
        chk("R3 leader short", 64'(rx_valid), 64'd0);
        pair(48, 40); bits_out(64'h5, 4, 1'b0); tail();
        expect_frame("R3 leader edge", 64'h5, 4); clear();
        pair(80, 20); bits_out(64'h5, 4, 1'b0); tail();
        chk("R3 leader long", 64'(rx_valid), 64'd0);
        bits_out(64'h5, 4, 1'b0); tail();
        chk("R3 missing leader", 64'(rx_valid), 64'd0);

        // R4 no leader required
        ctl_need_leader = 1'b0;
        bits_out(64'hA6, 8, 1'b1); tail();
        expect_frame("R4 no leader", 64'hA6, 8); clear();

        // R12 saturation: a wrapping count would alias to width 5
        pair(16389, 5); tail();
        chk("R12 saturated mark", 64'(rx_valid), 64'd0);
        ctl_need_leader = 1'b1;

        // R10 abort mid-frame then recovery
        pair(60, 40); bits_out(64'h3, 3, 1'b0); pair(8, 8); bits_out(64'h1, 2, 1'b0); tail();
        chk("R10 abort", 64'(rx_valid), 64'd0);
        frame(64'h2D, 6, 1'b0);
        expect_frame("R10 recovery", 64'h2D, 6); clear();

        // R5 lowered free-time threshold: gap at space >= 16
        gap_min = 8'd1;
        pair(70, 12); bits_out(64'hF, 4, 1'b0); pair(5, 40);
        expect_frame("R5 short spaces survive", 64'hF, 4); clear();
        pair(70, 12); bits_out(64'h3, 2, 1'b1); pair(5, 40);
        expect_frame("R5 long space ends frame", 64'd0, 0); clear();
        gap_min = 8'd10;
        repeat (150) @(negedge clk);

        // R6 length bounds with rounding and cap
        len_lo = 5'd9;
        frame(64'h7F, 7, 1'b0);
        chk("R6 below min", 64'(rx_valid), 64'd0);
        frame(64'hC3, 8, 1'b0);
        expect_frame("R6 at min", 64'hC3, 8); clear();
        len_lo = 5'd0;
        len_hi = 6'd41;
        frame(64'h12_3456_789A, 41, 1'b0);
        chk("R6 above max", 64'(rx_valid), 64'd0);
        frame(64'h12_3456_789A, 40, 1'b0);
        expect_frame("R6 at max", expv(64'h12_3456_789A, 40, 1'b0, 1'b0), 40); clear();
        len_hi = 6'd63;
        frame(64'h1_F0F0_F0F0_F0F0, 49, 1'b0);
        chk("R6 above cap", 64'(rx_valid), 64'd0);

        // R9 hold and drop while valid
        frame(64'h5A, 8, 1'b0);
        frame(64'hFF, 8, 1'b0);
        expect_frame("R9 second frame dropped", 64'h5A, 8);
        clear();
        chk("R9 cleared", 64'(rx_valid), 64'd0);

        // R11 enable off
        ctl_enable = 1'b0;
        frame(64'h33, 8, 1'b0);
        chk("R11 disabled", 64'(rx_valid), 64'd0);
        ctl_enable = 1'b1;
        repeat (150) @(negedge clk);
        frame(64'h33, 8, 1'b0);
        expect_frame("R11 re-enabled", 64'h33, 8); clear();

        summary();
        $finish;
    end
endmodule